// File: doc/BRIEF.md
# Single-Wire Debug Bit Transceiver

This block is the target-side bit engine of a half-duplex debug link that runs over one shared open-drain line. The host opens every bit time by pulling the line low, whatever the direction of the bit. The engine detects that falling edge through a synchronizer and counts target clock cycles from it. When receiving, it samples the host's level at a fixed point in the bit. When transmitting, it either holds the line low to send a 0, or leaves it released and adds a brief driven-high speedup pulse to send a 1.

A command layer asks for one transfer at a time: a byte or a word, in either direction, shifted most significant bit first. The engine reports the end of the transfer with a one-cycle done pulse and the received value. If the host produces no falling edge for a long stretch while a transfer is pending, the engine abandons the transfer and raises a one-cycle timeout flag. The level of the line during reset is latched as a mode-select output.

Top module: `dbglink_bit_engine`

## Requirements
- R1: While and just after reset, drv_low, drv_high, busy, xfer_done and timeout are all 0.
- R2: mode_sel takes the line level present during reset (low gives 0, high gives 1) and keeps it after reset whatever the line does.
- R3: In a receive transfer (xfer_tx=0), the host level at each bit's sample point enters the shift register MSB first. On done, xfer_rdata holds 8 bits in [7:0] with [15:8]=0 when xfer_word=0, or 16 bits when xfer_word=1.
- R4: xfer_done pulses for exactly one cycle, 14 cycles after the host's falling edge of the last bit, and busy is 0 from that cycle on.
- R5: When transmitting a 0, drv_low is 1 for exactly 10 cycles, from 3 to 12 cycles after the host's falling edge, so the line is still low 10 cycles after that edge.
- R6: When transmitting a 1, drv_low stays 0 and drv_high is 1 for exactly 2 consecutive cycles (7 and 8 cycles after the edge).
- R7: In a transmit transfer (xfer_tx=1), xfer_wdata goes out MSB first: bits [7:0] for a byte, [15:0] for a word.
- R8: With a transfer pending and no host falling edge, timeout pulses for one cycle 512 cycles after the start was taken. busy then drops and no done is given.
- R9: After a timeout, the next transfer starts again from its first bit, with no leftover bits from the abandoned one.
- R10: Host falling edges while no transfer is pending cause no drive, no done and no change of busy.
- R11: drv_low and drv_high are never 1 together, and neither is 1 during a receive transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level seen on the shared line (asynchronous) |
| drv_low | output | 1 | Enable of the pull-low driver |
| drv_high | output | 1 | Enable of the speedup driver (drives high) |
| mode_sel | output | 1 | Line level latched during reset |
| xfer_start | input | 1 | Request a transfer (taken only when idle) |
| xfer_tx | input | 1 | 1 = transmit to host, 0 = receive from host |
| xfer_word | input | 1 | 1 = 16 bits, 0 = 8 bits |
| xfer_wdata | input | 16 | Data to transmit |
| xfer_rdata | output | 16 | Received data, updated at done |
| xfer_done | output | 1 | One-cycle end of transfer pulse |
| busy | output | 1 | A transfer is pending |
| timeout | output | 1 | One-cycle abandon pulse |

## Verification
The hardest situation to reach is a timeout in the middle of a transfer that has already shifted part of its bits, followed by a clean transfer that must not inherit them. The bench sends three host bits of a byte receive, then stays silent until the timeout fires, and then runs a full byte with a known pattern. Random byte and word transfers in both directions, driven by a host model that checks drive cycles per bit, cover the normal timing.

// File: rtl/dbglink_pkg.sv
package dbglink_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ARMED = 2'd1,
    XS_BIT   = 2'd2
  } xfer_state_e;

  // number of bits in a transfer
  function automatic int xfer_bits(logic is_word, int byte_w, int word_w);
    return is_word ? word_w : byte_w;
  endfunction

  // pull-low enable for a transmitted bit at a given phase
  function automatic logic tx_low_at(logic b, int phase, int hold_end);
    return (!b) && (phase < hold_end);
  endfunction

  // speedup enable for a transmitted bit at a given phase
  function automatic logic tx_spd_at(logic b, int phase, int spd_at, int spd_len);
    return b && (phase >= spd_at) && (phase < spd_at + spd_len);
  endfunction

endpackage

// File: rtl/dbglink_edge_sync.sv
module dbglink_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync,
  output logic fall_det
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= line_in;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b1;
      else        chain[g] <= chain[g-1];
    end
  end

  assign line_sync = chain[STAGES-1];
  assign fall_det  = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/dbglink_timeout.sv
module dbglink_timeout #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !kick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || kick)   cnt <= '0;
    else if (expire)         cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbglink_shifter.sv
module dbglink_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/dbglink_bit_engine.sv
module dbglink_bit_engine
  import dbglink_pkg::*;
#(
  parameter int CLK_PER_BIT = 16,
  parameter int SAMPLE_PT   = 10,
  parameter int HOLD0_END   = 10,
  parameter int SPD_AT      = 4,
  parameter int SPD_LEN     = 2,
  parameter int TIMEOUT_CYC = 512,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              drv_low,
  output logic              drv_high,
  output logic              mode_sel,
  input  logic              xfer_start,
  input  logic              xfer_tx,
  input  logic              xfer_word,
  input  logic [WORD_W-1:0] xfer_wdata,
  output logic [WORD_W-1:0] xfer_rdata,
  output logic              xfer_done,
  output logic              busy,
  output logic              timeout
);
  localparam int PHASE_W = $clog2(CLK_PER_BIT);
  localparam int CNT_W   = $clog2(WORD_W + 1);
  localparam int PAD_W   = WORD_W - BYTE_W;
  localparam logic [PHASE_W-1:0] RX_END = PHASE_W'(SAMPLE_PT);
  localparam logic [PHASE_W-1:0] TX_END = PHASE_W'(HOLD0_END);

  // named internal events
  logic               line_sync;
  logic               fall_det;
  logic               to_expire;
  logic               bit_open;
  logic               bit_end;
  logic               last_bit;
  logic               tx_bit;
  logic               tx_mode;
  logic               take_start;

  xfer_state_e        state;
  logic [PHASE_W-1:0] phase;
  logic [CNT_W-1:0]   bits_left;
  logic               word_q;
  logic [WORD_W-1:0]  sh_q;
  logic [WORD_W-1:0]  sh_load;
  logic [WORD_W-1:0]  rx_final;
  logic               mode_q;

  dbglink_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .line_sync(line_sync), .fall_det(fall_det)
  );

  dbglink_timeout #(.LIMIT(TIMEOUT_CYC)) u_to (
    .clk(clk), .rst_n(rst_n), .run(state != XS_IDLE),
    .kick(fall_det), .expire(to_expire)
  );

  // transmit data is left-aligned so the MSB always sits at the top
  always_comb begin
    if (!xfer_tx)       sh_load = '0;
    else if (xfer_word) sh_load = xfer_wdata;
    else                sh_load = {xfer_wdata[BYTE_W-1:0], {PAD_W{1'b0}}};
  end

  dbglink_shifter #(.W(WORD_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(to_expire),
    .load(take_start), .load_val(sh_load),
    .shift(bit_end), .sin(line_sync), .q(sh_q)
  );

  assign take_start = (state == XS_IDLE) && xfer_start;
  assign bit_open   = (state == XS_BIT);
  assign bit_end    = bit_open && (phase == (tx_mode ? TX_END : RX_END));
  assign last_bit   = (bits_left == CNT_W'(1));
  assign tx_bit     = sh_q[WORD_W-1];
  assign rx_final   = {sh_q[WORD_W-2:0], line_sync};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= XS_IDLE;
      phase      <= '0;
      bits_left  <= '0;
      tx_mode    <= 1'b0;
      word_q     <= 1'b0;
      xfer_rdata <= '0;
      xfer_done  <= 1'b0;
      timeout    <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      timeout   <= 1'b0;
      if (to_expire) begin
        state     <= XS_IDLE;
        bits_left <= '0;
        phase     <= '0;
        timeout   <= 1'b1;
      end else begin
        unique case (state)
          XS_IDLE: if (xfer_start) begin
            state     <= XS_ARMED;
            tx_mode   <= xfer_tx;
            word_q    <= xfer_word;
            bits_left <= CNT_W'(xfer_bits(xfer_word, BYTE_W, WORD_W));
          end
          XS_ARMED: if (fall_det) begin
            state <= XS_BIT;
            phase <= '0;
          end
          XS_BIT: begin
            phase <= phase + 1'b1;
            if (bit_end) begin
              bits_left <= bits_left - 1'b1;
              if (last_bit) begin
                state     <= XS_IDLE;
                xfer_done <= 1'b1;
                if (!tx_mode)
                  xfer_rdata <= word_q ? rx_final
                                       : {{PAD_W{1'b0}}, rx_final[BYTE_W-1:0]};
              end else begin
                state <= XS_ARMED;
              end
            end
          end
          default: state <= XS_IDLE;
        endcase
      end
    end
  end

  // mode select: follows the line during reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= line_in;
  end
  assign mode_sel = mode_q;

  assign busy     = (state != XS_IDLE);
  assign drv_low  = bit_open && tx_mode && tx_low_at(tx_bit, int'(phase), HOLD0_END);
  assign drv_high = bit_open && tx_mode && tx_spd_at(tx_bit, int'(phase), SPD_AT, SPD_LEN);
endmodule

// File: rtl/dbglink_bit_engine_chk.sv
module dbglink_bit_engine_chk #(
  parameter int SPD_LEN = 2
) (
  input logic clk,
  input logic rst_n,
  input logic drv_low,
  input logic drv_high,
  input logic busy,
  input logic xfer_done,
  input logic timeout,
  input logic mode_sel,
  input logic tx_mode
);
  logic [3:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_run <= '0;
    else if (!drv_high)      hi_run <= '0;
    else if (hi_run != 4'hF) hi_run <= hi_run + 1'b1;
  end

  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_low && drv_high));
  a_r11_rx_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_mode) |-> (!drv_low && !drv_high));
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drv_low && !drv_high));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
  a_r8_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!busy && !xfer_done));
  a_r6_speedup_len: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hi_run) <= SPD_LEN);
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_sel));
endmodule

bind dbglink_bit_engine dbglink_bit_engine_chk #(.SPD_LEN(SPD_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_low(drv_low), .drv_high(drv_high),
  .busy(busy), .xfer_done(xfer_done), .timeout(timeout),
  .mode_sel(mode_sel), .tx_mode(tx_mode)
);

// File: tb/dbglink_bit_engine_bench.sv
`timescale 1ns/1ps
module dbglink_bit_engine_bench;
  localparam int TO_CYC = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic line;
  logic drv_low, drv_high, mode_sel, xfer_done, busy, timeout;
  logic xfer_start = 1'b0, xfer_tx = 1'b0, xfer_word = 1'b0;
  logic [15:0] xfer_wdata = '0;
  logic [15:0] xfer_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign line = !(host_low || drv_low);

  dbglink_bit_engine u_dbglink_bit_engine (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .drv_low(drv_low), .drv_high(drv_high), .mode_sel(mode_sel),
    .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_word(xfer_word),
    .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata),
    .xfer_done(xfer_done), .busy(busy), .timeout(timeout)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits(bit w);
    return w ? 16 : 8;
  endfunction
  function automatic bit bit_at(logic [15:0] d, bit w, int i);
    return d[nbits(w) - 1 - i];
  endfunction
  function automatic int exp_rx(logic [15:0] d, bit w);
    return w ? int'(d) : int'(d[7:0]);
  endfunction

  task automatic do_reset(bit lvl);
    rst_n = 1'b0;
    host_low = !lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic start_xfer(bit tx, bit w, logic [15:0] d);
    @(negedge clk);
    xfer_start = 1'b1; xfer_tx = tx; xfer_word = w; xfer_wdata = d;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  // host sends one bit; reports at which cycle done was seen
  task automatic host_send(bit b, output int done_at, output int rdat);
    done_at = -1; rdat = 0;
    @(negedge clk);
    host_low = 1'b1;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (i == (b ? 4 : 14)) host_low = 1'b0;
      if (xfer_done && done_at < 0) begin done_at = i; rdat = int'(xfer_rdata); end
    end
  endtask

  // host reads one bit; counts drive cycles
  task automatic host_recv(output bit b, output int lo_n, output int hi_n,
                           output int lo_first, output int done_at);
    lo_n = 0; hi_n = 0; lo_first = -1; done_at = -1; b = 1'b0;
    @(negedge clk);
    host_low = 1'b1;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (i == 4) host_low = 1'b0;
      if (drv_low) begin lo_n++; if (lo_first < 0) lo_first = i; end
      if (drv_high) hi_n++;
      if (i == 10) b = line;
      if (xfer_done && done_at < 0) done_at = i;
    end
  endtask

  task automatic rx_xfer(bit w, logic [15:0] d, string req);
    int da, rd, got;
    got = -1;
    start_xfer(1'b0, w, d);
    for (int i = 0; i < nbits(w); i++) begin
      host_send(bit_at(d, w, i), da, rd);
      if (i == nbits(w) - 1) begin
        chk({req, " R4 done cycle"}, da, 14);
        got = rd;
      end else chk({req, " R4 no early done"}, da, -1);
    end
    chk({req, " R3 rdata"}, got, exp_rx(d, w));
    chk({req, " R4 busy after"}, int'(busy), 0);
  endtask

  task automatic tx_xfer(bit w, logic [15:0] d, string req);
    bit b; int lo, hi, lf, da;
    int got;
    got = 0;
    start_xfer(1'b1, w, d);
    for (int i = 0; i < nbits(w); i++) begin
      host_recv(b, lo, hi, lf, da);
      got = (got << 1) | int'(b);
      if (bit_at(d, w, i)) begin
        chk({req, " R6 no low"}, lo, 0);
        chk({req, " R6 speedup len"}, hi, 2);
      end else begin
        chk({req, " R5 low len"}, lo, 10);
        chk({req, " R5 low start"}, lf, 3);
        chk({req, " R11 no speedup on 0"}, hi, 0);
      end
      if (i == nbits(w) - 1) chk({req, " R4 tx done"}, da, 14);
    end
    chk({req, " R7 bits out"}, got, exp_rx(d, w));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int da, rd, cnt, seen_done;
    bit b; int lo, hi, lf;
    void'($urandom(32'h5EED_0042));

    // R1 and R2 with the line low during reset
    host_low = 1'b1;
    #1;
    repeat (3) @(negedge clk);
    chk("R1 drv_low", int'(drv_low), 0);
    chk("R1 drv_high", int'(drv_high), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(xfer_done), 0);
    chk("R1 timeout", int'(timeout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    host_low = 1'b0;
    chk("R2 mode low", int'(mode_sel), 0);
    repeat (5) @(negedge clk);
    chk("R2 mode held", int'(mode_sel), 0);
    do_reset(1'b1);
    chk("R2 mode high", int'(mode_sel), 1);
    host_low = 1'b1; repeat (4) @(negedge clk); host_low = 1'b0;
    chk("R2 mode held after toggle", int'(mode_sel), 1);

    // R10: host edges with no transfer pending
    for (int k = 0; k < 3; k++) begin
      host_recv(b, lo, hi, lf, da);
      chk("R10 idle no low", lo, 0);
      chk("R10 idle no high", hi, 0);
      chk("R10 idle no done", da, -1);
      chk("R10 idle busy", int'(busy), 0);
    end

    // directed transfers
    rx_xfer(1'b0, 16'h00A5, "dir rx byte");
    rx_xfer(1'b1, 16'h8001, "dir rx word");
    rx_xfer(1'b0, 16'hFF00, "dir rx byte upper ignored");
    tx_xfer(1'b0, 16'h12C3, "dir tx byte");
    tx_xfer(1'b1, 16'hF00F, "dir tx word");

    // R8: no edges at all
    start_xfer(1'b0, 1'b0, 16'h0);
    cnt = 0; seen_done = 0;
    while (!timeout && cnt < 700) begin
      @(negedge clk); cnt++;
      if (xfer_done) seen_done = 1;
    end
    chk("R8 timeout cycle", cnt, TO_CYC);
    chk("R8 busy after timeout", int'(busy), 0);
    chk("R8 no done", seen_done, 0);
    @(negedge clk);
    chk("R8 timeout single cycle", int'(timeout), 0);

    // R9: partial receive, timeout, then a clean byte
    start_xfer(1'b0, 1'b0, 16'h0);
    for (int i = 0; i < 3; i++) host_send(1'b1, da, rd);
    cnt = 0;
    while (!timeout && cnt < 700) begin @(negedge clk); cnt++; end
    chk("R9 timeout reached", int'(cnt < 700), 1);
    rx_xfer(1'b0, 16'h005A, "R9 after timeout");
    tx_xfer(1'b0, 16'h0081, "R9 tx after timeout");

    // random transfers
    for (int k = 0; k < 24; k++) begin
      logic [15:0] d;
      bit tx, w;
      d  = 16'($urandom);
      tx = 1'($urandom);
      w  = 1'($urandom);
      if (tx) tx_xfer(w, d, "rand tx");
      else    rx_xfer(w, d, "rand rx");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule